// File: doc/BRIEF.md
# Pipeline Stall and Bubble Controller

This block steers the pipe registers of a five-stage in-order pipeline (fetch, decode, execute, memory, write-back). On every clock update it tells each of the five pipe registers what to do. A register can load its next state as usual. It can hold its present contents, which is a stall. Or it can be forced to all zeros, which is a bubble. The all-zero value of every pipe register must act as a no-op in the stage that reads it. The five registers are the program counter, IF/ID, ID/EX, EX/MEM and MEM/WB.

The controller takes four event flags:

- an instruction-fetch miss
- a data-access miss
- a load-use hazard reported by the forwarding logic
- a taken-branch decision made while the branch sits in the memory stage

Branches are predicted not taken, and the one instruction after a branch always runs. So a taken branch only has to squash the two younger instructions fetched after that slot. The delay slot itself moves on untouched.

When several flags are raised in the same cycle, one cause is picked by a fixed priority. A small amount of state keeps a load-use stall to exactly one cycle. The block also contains a parameterised pipe-register wrapper that obeys the hold and clear bits. Five of these wrappers form a tag pipeline, so the effect of each decision can be seen at the ports.

Top module: `pipe_flow_ctrl`

## Requirements
- R1: While reset is high and on the first cycle after it, every stage tag reads zero. With all event flags low after reset, all hold and clear bits are zero.
- R2: With no event flag active, no hold or clear bit is set. On each edge, slot 0 takes `fetch_tag` and slot k takes the old value of slot k-1.
- R3: A slot whose hold bit is set keeps its value across the edge. A slot whose clear bit is set reads zero after the edge.
- R4: A fetch miss alone gives hold = 5'b00001 and clear = 5'b00010, with bit 0 = PC, 1 = IF/ID, 2 = ID/EX, 3 = EX/MEM and 4 = MEM/WB.
- R5: A data miss gives hold = 5'b01111 and clear = 5'b10000, whatever the other flags are.
- R6: An accepted load-use hazard gives hold = 5'b00011 and clear = 5'b00100.
- R7: A load-use flag in the update right after an accepted load-use stall is ignored. Updates frozen by a data miss do not count, so the ignore carries across them. The outputs then follow the remaining flags as if load-use were low.
- R8: A taken branch without a data miss gives hold = 5'b00000 and clear = 5'b00110. The delay slot in ID/EX therefore passes unchanged into EX/MEM.
- R9: Priority from highest to lowest is data miss, taken branch, load-use, fetch miss.
- R10: The hold bits always form a run starting at bit 0, and a hold bit and a clear bit are never both set for one register. In every stall pattern, the single clear bit is the one just above the highest hold bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| icache_miss | input | 1 | Instruction fetch miss this cycle |
| dcache_miss | input | 1 | Data access miss this cycle |
| load_use | input | 1 | Consumer in decode needs a load now in execute |
| br_taken | input | 1 | Branch in the memory stage resolved taken |
| fetch_tag | input | DW | Value offered to the PC slot of the tag pipeline |
| stall_o | output | 5 | Hold bit per register (bit 0 = PC ... bit 4 = MEM/WB) |
| bubble_o | output | 5 | Clear bit per register (same order) |
| stage_tag_o | output | 5*DW | Tag pipeline contents, slot k at bits k*DW +: DW |

## Verification
Each flag is first raised on its own in the middle of a stream of rising fetch tags. The tag shifts then show which slots froze, which turned to zero and which advanced. Load-use is then held for two updates in a row, and again with a data-miss freeze wedged between them. These runs separate a one-cycle stall from a stall that repeats, and show whether the freeze clears the one-shot state when it should not. Pairs and triples of flags, followed by a long run with sparse random flags, show that the priority order is right. A reference model steps alongside the design on every clock.

// File: rtl/pipe_flow_pkg.sv
package pipe_flow_pkg;
    localparam int NREG      = 5;
    localparam int IDX_PC    = 0;
    localparam int IDX_IFID  = 1;
    localparam int IDX_IDEX  = 2;
    localparam int IDX_EXMEM = 3;
    localparam int IDX_MEMWB = 4;

    typedef logic [NREG-1:0] regmask_t;

    typedef enum logic [2:0] {
        CZ_NONE,
        CZ_IMISS,
        CZ_LDUSE,
        CZ_BRANCH,
        CZ_DMISS
    } cause_e;

    typedef struct packed {
        regmask_t hold;
        regmask_t clear;
    } flow_ctl_t;

    // Bits 0..last set: a stall on one register freezes every older stage too.
    function automatic regmask_t upto(input int last);
        regmask_t m;
        for (int i = 0; i < NREG; i++) m[i] = (i <= last);
        return m;
    endfunction

    function automatic regmask_t at(input int idx);
        regmask_t m;
        for (int i = 0; i < NREG; i++) m[i] = (i == idx);
        return m;
    endfunction

    function automatic flow_ctl_t ctl_of(input cause_e c);
        flow_ctl_t r;
        r.hold  = '0;
        r.clear = '0;
        case (c)
            CZ_DMISS: begin
                r.hold  = upto(IDX_EXMEM);
                r.clear = at(IDX_MEMWB);
            end
            CZ_BRANCH: begin
                r.clear = at(IDX_IFID) | at(IDX_IDEX);
            end
            CZ_LDUSE: begin
                r.hold  = upto(IDX_IFID);
                r.clear = at(IDX_IDEX);
            end
            CZ_IMISS: begin
                r.hold  = upto(IDX_PC);
                r.clear = at(IDX_IFID);
            end
            default: ;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/flow_arbiter.sv
module flow_arbiter
    import pipe_flow_pkg::*;
(
    input  logic   icache_miss,
    input  logic   dcache_miss,
    input  logic   load_use,
    input  logic   br_taken,
    input  logic   ldu_mask,
    output cause_e cause
);
    always_comb begin
        if (dcache_miss)                cause = CZ_DMISS;
        else if (br_taken)              cause = CZ_BRANCH;
        else if (load_use && !ldu_mask) cause = CZ_LDUSE;
        else if (icache_miss)           cause = CZ_IMISS;
        else                            cause = CZ_NONE;
    end
endmodule

// File: rtl/ldu_guard.sv
module ldu_guard
    import pipe_flow_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_e cause,
    output logic   ldu_mask
);
    // A frozen update leaves the pipeline unchanged, so the mask is kept too.
    always_ff @(posedge clk) begin
        if (rst)
            ldu_mask <= 1'b0;
        else if (cause != CZ_DMISS)
            ldu_mask <= (cause == CZ_LDUSE);
    end
endmodule

// File: rtl/pipe_stage_reg.sv
module pipe_stage_reg #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          clear,
    input  logic [DW-1:0] d,
    output logic [DW-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clear)
            q <= '0;
        else if (!hold)
            q <= d;
    end
endmodule

// File: rtl/pipe_flow_ctrl.sv
module pipe_flow_ctrl
    import pipe_flow_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               icache_miss,
    input  logic               dcache_miss,
    input  logic               load_use,
    input  logic               br_taken,
    input  logic [DW-1:0]      fetch_tag,
    output logic [NREG-1:0]    stall_o,
    output logic [NREG-1:0]    bubble_o,
    output logic [NREG*DW-1:0] stage_tag_o
);
    cause_e    cause;
    logic      ldu_mask;
    flow_ctl_t ctl;

    flow_arbiter u_arb (
        .icache_miss (icache_miss),
        .dcache_miss (dcache_miss),
        .load_use    (load_use),
        .br_taken    (br_taken),
        .ldu_mask    (ldu_mask),
        .cause       (cause)
    );

    ldu_guard u_guard (
        .clk      (clk),
        .rst      (rst),
        .cause    (cause),
        .ldu_mask (ldu_mask)
    );

    assign ctl      = ctl_of(cause);
    assign stall_o  = ctl.hold;
    assign bubble_o = ctl.clear;

    logic [DW-1:0] tag_d [NREG];
    logic [DW-1:0] tag_q [NREG];

    for (genvar k = 0; k < NREG; k++) begin : g_slot
        if (k == 0) begin : g_head
            assign tag_d[k] = fetch_tag;
        end else begin : g_body
            assign tag_d[k] = tag_q[k-1];
        end

        pipe_stage_reg #(.DW(DW)) u_reg (
            .clk   (clk),
            .rst   (rst),
            .hold  (ctl.hold[k]),
            .clear (ctl.clear[k]),
            .d     (tag_d[k]),
            .q     (tag_q[k])
        );

        assign stage_tag_o[k*DW +: DW] = tag_q[k];
    end
endmodule

// File: rtl/pipe_flow_chk.sv
module pipe_flow_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic          icache_miss,
    input logic          dcache_miss,
    input logic          load_use,
    input logic          br_taken,
    input logic [4:0]    stall_o,
    input logic [4:0]    bubble_o,
    input logic [5*DW-1:0] stage_tag_o
);
    // R10
    stall_run_chk: assert property (@(posedge clk) disable iff (rst)
        ((stall_o & (stall_o + 5'd1)) == 5'd0));

    // R10
    hold_clear_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
        ((stall_o & bubble_o) == 5'd0));

    // R5
    dmiss_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        dcache_miss |-> (stall_o == 5'b01111 && bubble_o == 5'b10000));

    // R8
    branch_squash_chk: assert property (@(posedge clk) disable iff (rst)
        (br_taken && !dcache_miss) |-> (stall_o == 5'b00000 && bubble_o == 5'b00110));

    // R4
    imiss_only_chk: assert property (@(posedge clk) disable iff (rst)
        (icache_miss && !dcache_miss && !br_taken && !load_use)
            |-> (stall_o == 5'b00001 && bubble_o == 5'b00010));

    // R7
    ldu_once_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(stall_o == 5'b00011) && !dcache_miss)
            |-> (stall_o != 5'b00011));

    for (genvar k = 0; k < 5; k++) begin : g_slot_chk
        // R3
        slot_hold_chk: assert property (@(posedge clk) disable iff (rst)
            stall_o[k] |=> $stable(stage_tag_o[k*DW +: DW]));

        // R3
        slot_clear_chk: assert property (@(posedge clk) disable iff (rst)
            bubble_o[k] |=> (stage_tag_o[k*DW +: DW] == '0));
    end
endmodule

bind pipe_flow_ctrl pipe_flow_chk #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .icache_miss (icache_miss),
    .dcache_miss (dcache_miss),
    .load_use    (load_use),
    .br_taken    (br_taken),
    .stall_o     (stall_o),
    .bubble_o    (bubble_o),
    .stage_tag_o (stage_tag_o)
);

// File: tb/sim_pipe_flow_ctrl.sv
module sim_pipe_flow_ctrl;
    localparam int DW = 8;
    localparam int NR = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic icache_miss = 1'b0, dcache_miss = 1'b0, load_use = 1'b0, br_taken = 1'b0;
    logic [DW-1:0] fetch_tag = '0;
    logic [NR-1:0] stall_o, bubble_o;
    logic [NR*DW-1:0] stage_tag_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    int exp_tag [NR];
    bit mdl_mask;
    logic [7:0] tag_ctr = 8'd1;

    always #2 clk = ~clk;

    pipe_flow_ctrl #(.DW(DW)) u0 (
        .clk(clk), .rst(rst),
        .icache_miss(icache_miss), .dcache_miss(dcache_miss),
        .load_use(load_use), .br_taken(br_taken),
        .fetch_tag(fetch_tag),
        .stall_o(stall_o), .bubble_o(bubble_o),
        .stage_tag_o(stage_tag_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic check_tags(input string req);
        for (int k = 0; k < NR; k++)
            check(req, $sformatf("slot%0d tag", k), int'(stage_tag_o[k*DW +: DW]), exp_tag[k]);
    endtask

    // One clock update: drive flags, compare control, step model, compare tags.
    task automatic step(input bit im, input bit dm, input bit lu, input bit bt, input logic [7:0] tg);
        logic [4:0] es, eb;
        string req;
        int nxt [NR];
        int nflags;
        bit mask_n;
        @(negedge clk);
        icache_miss = im; dcache_miss = dm; load_use = lu; br_taken = bt; fetch_tag = tg;
        #1;
        nflags = int'(im) + int'(dm) + int'(lu) + int'(bt);
        mask_n = mdl_mask;
        if (dm) begin
            es = 5'b01111; eb = 5'b10000; req = "R5";
        end else if (bt) begin
            es = 5'b00000; eb = 5'b00110; req = "R8"; mask_n = 0;
        end else if (lu && !mdl_mask) begin
            es = 5'b00011; eb = 5'b00100; req = "R6"; mask_n = 1;
        end else if (im) begin
            es = 5'b00001; eb = 5'b00010; req = "R4"; mask_n = 0;
        end else begin
            es = 5'b00000; eb = 5'b00000; req = "R2"; mask_n = 0;
        end
        if (lu && mdl_mask && !dm) req = "R7";
        else if (nflags > 1) req = "R9";
        check(req, "stall", int'(stall_o), int'(es));
        check(req, "bubble", int'(bubble_o), int'(eb));
        // R10 checked at the ports independently of the chosen cause
        check("R10", "stall run/overlap",
              int'(((stall_o & (stall_o + 5'd1)) == 0) && ((stall_o & bubble_o) == 0)), 1);
        for (int k = 0; k < NR; k++) begin
            if (eb[k])       nxt[k] = 0;
            else if (es[k])  nxt[k] = exp_tag[k];
            else             nxt[k] = (k == 0) ? int'(tg) : exp_tag[k-1];
        end
        @(posedge clk);
        #1;
        for (int k = 0; k < NR; k++) exp_tag[k] = nxt[k];
        mdl_mask = mask_n;
        check_tags((es != 0 || eb != 0) ? "R3" : "R2");
    endtask

    task automatic flow(input int n);
        for (int i = 0; i < n; i++) begin
            step(0, 0, 0, 0, tag_ctr);
            tag_ctr++;
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NR; k++) exp_tag[k] = 0;
        mdl_mask = 0;
        repeat (3) @(posedge clk);
        #1;
        check_tags("R1");
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1", "stall after reset", int'(stall_o), 0);
        check("R1", "bubble after reset", int'(bubble_o), 0);
        check_tags("R1");

        flow(6);                                 // R2 plain shifting
        step(1, 0, 0, 0, 8'hA0); flow(3);        // R4 fetch miss
        step(0, 1, 0, 0, 8'hA1);                 // R5 freeze, three cycles
        step(0, 1, 1, 1, 8'hA2);
        step(1, 1, 0, 0, 8'hA3);
        flow(3);
        step(0, 0, 1, 0, 8'hB0);                 // R6 load-use
        step(0, 0, 1, 0, 8'hB1);                 // R7 second one ignored
        flow(2);
        step(0, 0, 1, 0, 8'hB2);                 // R7 mask kept across freeze
        step(0, 1, 1, 0, 8'hB3);
        step(0, 1, 0, 0, 8'hB4);
        step(1, 0, 1, 0, 8'hB5);                 // ignored load-use, fetch miss shows
        flow(3);
        step(0, 0, 0, 1, 8'hC0); flow(2);        // R8 taken branch
        step(0, 0, 1, 1, 8'hC1);                 // R9 branch over load-use
        step(0, 0, 1, 0, 8'hC2);                 // load-use accepted after branch
        flow(1);
        step(1, 0, 1, 0, 8'hC3);                 // R9 load-use over fetch miss
        step(1, 0, 0, 1, 8'hC4);                 // R9 branch over fetch miss
        step(1, 1, 1, 1, 8'hC5);                 // R9 data miss over all
        flow(3);

        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 6) == 0, ($urandom % 8) == 0, ($urandom % 5) == 0,
                 ($urandom % 7) == 0, 8'($urandom));
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule